// File: doc/BRIEF.md
# Exception Entry Controller

This block sits beside the execute stage of a small 32-bit RISC core. It decides which pending exception is taken and produces every state update that entering its handler needs. Seven request lines come in: reset, data abort, fast interrupt (FIQ), normal interrupt (IRQ), prefetch abort, undefined instruction and software interrupt. The block also receives the current status word and the address of the instruction that follows the faulting one. From these it issues the following in one step:

- the handler vector for the program counter;
- a link-register write and a saved-status write, both tagged with the target mode so that the banked register file can steer them;
- the new current status word.

The same block also handles return from an exception. A return request loads the current status word from the saved copy of the current mode and sends the program counter to the supplied return address. All outputs are registered. Inputs sampled at one rising edge appear on the outputs after that edge and hold for one cycle. When nothing is taken and no return is accepted, every output is zero.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Among unmasked requests, exactly one is taken per cycle. The order from highest to lowest is reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt. `take` pulses for one cycle. `cause` is one-hot with bit 0 reset, bit 1 data abort, bit 2 FIQ, bit 3 IRQ, bit 4 prefetch abort, bit 5 undefined, bit 6 software interrupt.
- R2: Undefined instruction and software interrupt share the lowest level. When both are raised together, undefined is taken.
- R3: `pc_out` on entry is 0x00 for reset, 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 IRQ and 0x1C FIQ. 0x14 is never issued.
- R4: The target mode goes on `lr_mode`, on `spsr_mode` and into status bits [4:0]. Reset and software interrupt map to supervisor 10011. Both aborts map to abort 10111. Undefined maps to 11011, IRQ to 10010 and FIQ to 10001.
- R5: On entry `lr_we` and `spsr_we` are 1, `lr_data` equals the sampled `next_pc`, and `spsr_data` equals the sampled `cur_status`.
- R6: The new status word sets I (bit 7) and clears T (bit 5). F (bit 6) is set on FIQ and reset entry and is otherwise kept. N, Z, C, V (bits 31..28) and bits 27..8 are kept unchanged.
- R7: IRQ is ignored while `cur_status` bit 7 is 1, and FIQ is ignored while bit 6 is 1. A masked source lets the next lower source win. Reset is taken whatever the mask bits are.
- R8: A return request with no exception taken makes `pc_we` 1 with `pc_out` equal to `ret_pc`, and `status_we` 1 with `status_out` equal to `spsr_cur`. In that cycle `take`, `lr_we` and `spsr_we` stay 0.
- R9: A return request is ignored when the current mode (status bits [4:0]) is user 10000 or system 11111, because neither mode has a saved status. All outputs stay zero.
- R10: When an exception and a return request arrive in the same cycle, the exception entry is produced and the return is dropped.
- R11: Outputs change one clock after the inputs are sampled. While `rst` is high, and in any cycle with nothing to do, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block's registers |
| req_reset | input | 1 | Reset exception request |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| ret_req | input | 1 | Return-from-exception request |
| cur_status | input | 32 | Current status word |
| spsr_cur | input | 32 | Saved status word of the current mode |
| next_pc | input | XLEN | Address of the instruction after the faulting one |
| ret_pc | input | XLEN | Resume address for a return |
| take | output | 1 | Exception taken this cycle |
| cause | output | 7 | One-hot taken source |
| pc_we | output | 1 | Program counter write |
| pc_out | output | XLEN | New program counter |
| lr_we | output | 1 | Banked link register write |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_data | output | XLEN | Link register value |
| spsr_we | output | 1 | Saved status write |
| spsr_mode | output | 5 | Mode whose saved status is written |
| spsr_data | output | 32 | Saved status value |
| status_we | output | 1 | Current status write |
| status_out | output | 32 | New current status word |

## Verification
Two functions can land in the same cycle: exception entry and exception return. Both want to drive the program counter and the status word. The bench raises `ret_req` together with an unmasked IRQ, and again together with an IRQ masked by I. It judges the result from the write enables and data on the following clock. In the first case the result must be a full IRQ entry with the return dropped. In the second case it must be a clean return. Stacked and masked requests are raised the same way, and the bench checks which one-hot cause survives.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int NSRC   = 7;
    localparam int STAT_W = 32;
    localparam int MODE_W = 5;

    // Source index doubles as priority rank (0 = highest)
    typedef enum int {
        SRC_RST  = 0,
        SRC_DABT = 1,
        SRC_FIQ  = 2,
        SRC_IRQ  = 3,
        SRC_PABT = 4,
        SRC_UND  = 5,
        SRC_SWI  = 6
    } src_e;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    typedef struct packed {
        logic              neg;
        logic              zero;
        logic              carry;
        logic              ovf;
        logic [19:0]       resv;
        logic              irq_off;
        logic              fiq_off;
        logic              thumb;
        logic [MODE_W-1:0] mode;
    } status_t;

    function automatic logic [7:0] vec_offset(int idx);
        case (idx)
            SRC_RST:  return 8'h00;
            SRC_UND:  return 8'h04;
            SRC_SWI:  return 8'h08;
            SRC_PABT: return 8'h0C;
            SRC_DABT: return 8'h10;
            SRC_IRQ:  return 8'h18;
            SRC_FIQ:  return 8'h1C;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic logic [MODE_W-1:0] target_mode(int idx);
        case (idx)
            SRC_RST, SRC_SWI:   return MODE_SVC;
            SRC_DABT, SRC_PABT: return MODE_ABT;
            SRC_UND:            return MODE_UND;
            SRC_IRQ:            return MODE_IRQ;
            SRC_FIQ:            return MODE_FIQ;
            default:            return MODE_SVC;
        endcase
    endfunction

    function automatic logic masks_fiq(int idx);
        return (idx == SRC_RST) || (idx == SRC_FIQ);
    endfunction

    function automatic logic has_saved(logic [MODE_W-1:0] m);
        return (m != MODE_USR) && (m != MODE_SYS);
    endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
    import exc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] req,
    input  logic         irq_off,
    input  logic         fiq_off,
    output logic [N-1:0] grant,
    output logic         any
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] live;

    // Per-source gating: maskable interrupts drop out when disabled
    for (genvar i = 0; i < N; i++) begin : g_gate
        if (i == int'(SRC_IRQ)) begin : g_irq
            assign live[i] = req[i] & ~irq_off;
        end else if (i == int'(SRC_FIQ)) begin : g_fiq
            assign live[i] = req[i] & ~fiq_off;
        end else begin : g_plain
            assign live[i] = req[i];
        end
    end

    // Isolate lowest set index (= highest priority)
    assign grant = live & (~live + ONE);
    assign any   = |live;
endmodule

// File: rtl/exc_vec_map.sv
module exc_vec_map
    import exc_pkg::*;
#(
    parameter int N    = NSRC,
    parameter int XLEN = 32
) (
    input  logic [N-1:0]      grant,
    output logic [XLEN-1:0]   vec,
    output logic [MODE_W-1:0] mode,
    output logic              fmask
);
    logic [N-1:0][XLEN-1:0]   vec_t;
    logic [N-1:0][MODE_W-1:0] mode_t;

    for (genvar i = 0; i < N; i++) begin : g_row
        assign vec_t[i]  = grant[i] ? XLEN'(vec_offset(i)) : '0;
        assign mode_t[i] = grant[i] ? target_mode(i) : '0;
    end

    always_comb begin
        vec   = '0;
        mode  = '0;
        fmask = 1'b0;
        for (int i = 0; i < N; i++) begin
            vec   = vec | vec_t[i];
            mode  = mode | mode_t[i];
            fmask = fmask | (grant[i] & masks_fiq(i));
        end
    end
endmodule

// File: rtl/exc_status_gen.sv
module exc_status_gen
    import exc_pkg::*;
(
    input  status_t           cur,
    input  logic [MODE_W-1:0] mode,
    input  logic              fmask,
    output status_t           nxt
);
    always_comb begin
        nxt         = cur;
        nxt.mode    = mode;
        nxt.irq_off = 1'b1;
        nxt.thumb   = 1'b0;
        if (fmask) nxt.fiq_off = 1'b1;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_reset,
    input  logic              req_dabt,
    input  logic              req_fiq,
    input  logic              req_irq,
    input  logic              req_pabt,
    input  logic              req_und,
    input  logic              req_swi,
    input  logic              ret_req,
    input  logic [STAT_W-1:0] cur_status,
    input  logic [STAT_W-1:0] spsr_cur,
    input  logic [XLEN-1:0]   next_pc,
    input  logic [XLEN-1:0]   ret_pc,
    output logic              take,
    output logic [NSRC-1:0]   cause,
    output logic              pc_we,
    output logic [XLEN-1:0]   pc_out,
    output logic              lr_we,
    output logic [MODE_W-1:0] lr_mode,
    output logic [XLEN-1:0]   lr_data,
    output logic              spsr_we,
    output logic [MODE_W-1:0] spsr_mode,
    output logic [STAT_W-1:0] spsr_data,
    output logic              status_we,
    output logic [STAT_W-1:0] status_out
);
    status_t           cur_s;
    status_t           nxt_s;
    logic [NSRC-1:0]   req_v;
    logic [NSRC-1:0]   grant;
    logic              any;
    logic [XLEN-1:0]   vec;
    logic [MODE_W-1:0] mode;
    logic              fmask;
    logic              ret_ok;

    assign cur_s = status_t'(cur_status);

    always_comb begin
        req_v           = '0;
        req_v[SRC_RST]  = req_reset;
        req_v[SRC_DABT] = req_dabt;
        req_v[SRC_FIQ]  = req_fiq;
        req_v[SRC_IRQ]  = req_irq;
        req_v[SRC_PABT] = req_pabt;
        req_v[SRC_UND]  = req_und;
        req_v[SRC_SWI]  = req_swi;
    end

    exc_prio_arb #(.N(NSRC)) u_arb (
        .req     (req_v),
        .irq_off (cur_s.irq_off),
        .fiq_off (cur_s.fiq_off),
        .grant   (grant),
        .any     (any)
    );

    exc_vec_map #(.N(NSRC), .XLEN(XLEN)) u_map (
        .grant (grant),
        .vec   (vec),
        .mode  (mode),
        .fmask (fmask)
    );

    exc_status_gen u_stat (
        .cur   (cur_s),
        .mode  (mode),
        .fmask (fmask),
        .nxt   (nxt_s)
    );

    // Return only from a mode that owns a saved status; entry wins
    assign ret_ok = ret_req & has_saved(cur_s.mode) & ~any;

    always_ff @(posedge clk) begin
        if (rst) begin
            take       <= 1'b0;
            cause      <= '0;
            pc_we      <= 1'b0;
            pc_out     <= '0;
            lr_we      <= 1'b0;
            lr_mode    <= '0;
            lr_data    <= '0;
            spsr_we    <= 1'b0;
            spsr_mode  <= '0;
            spsr_data  <= '0;
            status_we  <= 1'b0;
            status_out <= '0;
        end else begin
            take      <= any;
            cause     <= grant;
            pc_we     <= any | ret_ok;
            lr_we     <= any;
            spsr_we   <= any;
            status_we <= any | ret_ok;
            lr_mode   <= any ? mode : '0;
            spsr_mode <= any ? mode : '0;
            lr_data   <= any ? next_pc : '0;
            spsr_data <= any ? cur_status : '0;
            if (any) begin
                pc_out     <= vec;
                status_out <= STAT_W'(nxt_s);
            end else if (ret_ok) begin
                pc_out     <= ret_pc;
                status_out <= spsr_cur;
            end else begin
                pc_out     <= '0;
                status_out <= '0;
            end
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_reset,
    input logic              req_irq,
    input logic              req_fiq,
    input logic              ret_req,
    input logic [STAT_W-1:0] cur_status,
    input logic [XLEN-1:0]   next_pc,
    input logic              take,
    input logic [NSRC-1:0]   cause,
    input logic              pc_we,
    input logic [XLEN-1:0]   pc_out,
    input logic              lr_we,
    input logic              spsr_we,
    input logic              status_we,
    input logic [XLEN-1:0]   lr_data,
    input logic [STAT_W-1:0] spsr_data,
    input logic [STAT_W-1:0] status_out
);
    a_r1_cause_onehot: assert property (@(posedge clk) disable iff (rst)
        take |-> $countones(cause) == 1);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !take |-> (cause == '0) && !lr_we && !spsr_we);

    a_r7_reset_unmasked: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_reset)) |-> take && cause[0]);

    a_r7_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_irq) && $past(cur_status[7])) |-> !cause[3]);

    a_r7_fiq_masked: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_fiq) && $past(cur_status[6])) |-> !cause[2]);

    a_r3_no_reserved_vec: assert property (@(posedge clk) disable iff (rst)
        take |-> pc_out != XLEN'(32'h14));

    a_r6_entry_bits: assert property (@(posedge clk) disable iff (rst)
        take |-> status_out[7] && !status_out[5]);

    a_r5_link_saved: assert property (@(posedge clk) disable iff (rst)
        (take && !$past(rst)) |-> (lr_data == $past(next_pc)) && (spsr_data == $past(cur_status)));

    a_r10_entry_complete: assert property (@(posedge clk) disable iff (rst)
        take |-> lr_we && spsr_we && pc_we && status_we);

    a_r9_no_ret_unbanked: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !take && $past(ret_req) &&
         (($past(cur_status[4:0]) == MODE_USR) || ($past(cur_status[4:0]) == MODE_SYS)))
        |-> !pc_we && !status_we);
endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_reset  (req_reset),
    .req_irq    (req_irq),
    .req_fiq    (req_fiq),
    .ret_req    (ret_req),
    .cur_status (cur_status),
    .next_pc    (next_pc),
    .take       (take),
    .cause      (cause),
    .pc_we      (pc_we),
    .pc_out     (pc_out),
    .lr_we      (lr_we),
    .spsr_we    (spsr_we),
    .status_we  (status_we),
    .lr_data    (lr_data),
    .spsr_data  (spsr_data),
    .status_out (status_out)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_reset = 0, req_dabt = 0, req_fiq = 0, req_irq = 0;
    logic req_pabt = 0, req_und = 0, req_swi = 0, ret_req = 0;
    logic [31:0] cur_status = 32'h0000_0010;
    logic [31:0] spsr_cur = 32'h0;
    logic [XLEN-1:0] next_pc = '0;
    logic [XLEN-1:0] ret_pc = '0;

    logic            take;
    logic [6:0]      cause;
    logic            pc_we, lr_we, spsr_we, status_we;
    logic [XLEN-1:0] pc_out, lr_data;
    logic [4:0]      lr_mode, spsr_mode;
    logic [31:0]     spsr_data, status_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // expected values
    logic            e_take, e_pc_we, e_lr_we, e_sp_we, e_st_we;
    logic [6:0]      e_cause;
    logic [XLEN-1:0] e_pc, e_lr;
    logic [4:0]      e_lr_mode, e_sp_mode;
    logic [31:0]     e_sp, e_st;

    always #2 clk = ~clk;

    exc_entry_ctrl #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst(rst),
        .req_reset(req_reset), .req_dabt(req_dabt), .req_fiq(req_fiq),
        .req_irq(req_irq), .req_pabt(req_pabt), .req_und(req_und),
        .req_swi(req_swi), .ret_req(ret_req),
        .cur_status(cur_status), .spsr_cur(spsr_cur),
        .next_pc(next_pc), .ret_pc(ret_pc),
        .take(take), .cause(cause), .pc_we(pc_we), .pc_out(pc_out),
        .lr_we(lr_we), .lr_mode(lr_mode), .lr_data(lr_data),
        .spsr_we(spsr_we), .spsr_mode(spsr_mode), .spsr_data(spsr_data),
        .status_we(status_we), .status_out(status_out)
    );

    task automatic zero_exp();
        e_take = 0; e_cause = '0; e_pc_we = 0; e_pc = '0;
        e_lr_we = 0; e_lr_mode = '0; e_lr = '0;
        e_sp_we = 0; e_sp_mode = '0; e_sp = '0;
        e_st_we = 0; e_st = '0;
    endtask

    // Behavioural reference: priority chain over the requirement tables
    task automatic model();
        int idx;
        logic [4:0] m;
        logic [7:0] v;
        logic fbit;
        idx = -1;
        zero_exp();
        if (req_reset)                         idx = 0;
        else if (req_dabt)                     idx = 1;
        else if (req_fiq && !cur_status[6])    idx = 2;
        else if (req_irq && !cur_status[7])    idx = 3;
        else if (req_pabt)                     idx = 4;
        else if (req_und)                      idx = 5;
        else if (req_swi)                      idx = 6;
        if (idx >= 0) begin
            case (idx)
                0: begin v = 8'h00; m = 5'b10011; end
                1: begin v = 8'h10; m = 5'b10111; end
                2: begin v = 8'h1C; m = 5'b10001; end
                3: begin v = 8'h18; m = 5'b10010; end
                4: begin v = 8'h0C; m = 5'b10111; end
                5: begin v = 8'h04; m = 5'b11011; end
                default: begin v = 8'h08; m = 5'b10011; end
            endcase
            fbit = (idx == 0 || idx == 2) ? 1'b1 : cur_status[6];
            e_take = 1; e_cause = 7'(1 << idx);
            e_pc_we = 1; e_pc = XLEN'(v);
            e_lr_we = 1; e_lr_mode = m; e_lr = next_pc;
            e_sp_we = 1; e_sp_mode = m; e_sp = cur_status;
            e_st_we = 1; e_st = {cur_status[31:8], 1'b1, fbit, 1'b0, m};
        end else if (ret_req && cur_status[4:0] != 5'b10000 && cur_status[4:0] != 5'b11111) begin
            e_pc_we = 1; e_pc = ret_pc;
            e_st_we = 1; e_st = spsr_cur;
        end
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "take",       32'(take),       32'(e_take));
        chk(tag, "cause",      32'(cause),      32'(e_cause));
        chk(tag, "pc_we",      32'(pc_we),      32'(e_pc_we));
        chk(tag, "pc_out",     32'(pc_out),     32'(e_pc));
        chk(tag, "lr_we",      32'(lr_we),      32'(e_lr_we));
        chk(tag, "lr_mode",    32'(lr_mode),    32'(e_lr_mode));
        chk(tag, "lr_data",    32'(lr_data),    32'(e_lr));
        chk(tag, "spsr_we",    32'(spsr_we),    32'(e_sp_we));
        chk(tag, "spsr_mode",  32'(spsr_mode),  32'(e_sp_mode));
        chk(tag, "spsr_data",  spsr_data,       e_sp);
        chk(tag, "status_we",  32'(status_we),  32'(e_st_we));
        chk(tag, "status_out", status_out,      e_st);
    endtask

    // Inputs are set just after an edge; model; sample 1 ns after next edge
    task automatic cyc(string tag);
        model();
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic set_req(logic [6:0] r);
        {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_reset} = r;
    endtask

    task automatic idle();
        set_req('0);
        ret_req = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: reset state with requests pending
        set_req(7'h7F); ret_req = 1;
        repeat (3) @(posedge clk);
        #1;
        zero_exp();
        compare("R11");
        rst = 0;
        idle();
        cur_status = 32'hF000_0010;
        next_pc = 32'h0000_1004;
        cyc("R11");

        // Each source alone (R3 vectors, R4 modes, R5 link/saved, R6 bits)
        for (int i = 0; i < 7; i++) begin
            set_req(7'(1 << i));
            cur_status = 32'h5000_0030;
            next_pc = 32'h0000_2000 + 32'(i * 4);
            cyc("R3");
            idle();
            cyc("R11");
        end
        set_req(7'h04); cur_status = 32'hA000_0010; cyc("R4");
        set_req(7'h20); cur_status = 32'h9000_0050; cyc("R6");
        set_req(7'h08); cur_status = 32'h3000_0011; next_pc = 32'hDEAD_BEE0; cyc("R5");

        // Priority pairs (R1) and shared lowest level (R2)
        cur_status = 32'h0000_0010;
        set_req(7'h06); cyc("R1");
        set_req(7'h0C); cyc("R1");
        set_req(7'h18); cyc("R1");
        set_req(7'h50); cyc("R1");
        set_req(7'h7F); cyc("R1");
        set_req(7'h7E); cyc("R1");
        set_req(7'h60); cyc("R2");

        // Masking (R7)
        cur_status = 32'h0000_0090;
        set_req(7'h18); cyc("R7");
        set_req(7'h08); cyc("R7");
        cur_status = 32'h0000_0050;
        set_req(7'h0C); cyc("R7");
        cur_status = 32'h0000_00D0;
        set_req(7'h0D); cyc("R7");
        set_req(7'h0C); cyc("R7");

        // Return (R8, R9, R10)
        idle();
        spsr_cur = 32'h6000_0010; ret_pc = 32'h0000_4444;
        cur_status = 32'h0000_0092; ret_req = 1; cyc("R8");
        cur_status = 32'h0000_0010; ret_req = 1; cyc("R9");
        cur_status = 32'h0000_001F; ret_req = 1; cyc("R9");
        cur_status = 32'h0000_0013; ret_req = 1; set_req(7'h08); cyc("R10");
        cur_status = 32'h0000_0093; ret_req = 1; set_req(7'h08); cyc("R10");
        idle(); cyc("R11");

        // Mixed random traffic
        for (int k = 0; k < 400; k++) begin
            set_req(7'($urandom) & 7'($urandom));
            ret_req    = 1'($urandom);
            cur_status = $urandom;
            if ($urandom % 2 == 0) cur_status[4:0] = 5'b10010;
            spsr_cur   = $urandom;
            next_pc    = $urandom;
            ret_pc     = $urandom;
            cyc("R1");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule